// File: doc/BRIEF.md
# Machine-Cycle State Sequencer with Bus Strobes

This block produces the timing skeleton for a small 8-bit controller core. It counts oscillator periods into machine cycles of six states, each split into a first and a second phase, so one machine cycle lasts twelve clocks. It decodes that count into single-clock pulses for the core: latch the opcode, fetch a second code byte, and advance the program counter. It also drives the strobes of a multiplexed external address/data bus: an address-latch pulse and an active-low code-read strobe.

Two code fetches happen in every ordinary machine cycle, whether or not the instruction needs the bytes. The address-latch pulse keeps running when code comes from on-chip memory, so it can serve as a clock output. Only the code-read strobe depends on where program memory sits. A two-cycle external data move is announced by the core on `xdata_op`, together with its direction on `xdata_write`. The cycle that follows is then a data cycle. In a data cycle the fetch pulses, both address-latch pulses and both code-read strobes are withheld, and a read or write window is opened on the bus instead.

Top module: `mcycle_sequencer`

## Requirements
- R1: `state_oh` is one-hot, with bit i meaning state S(i+1), and `phase2` is high in the second phase. The sequencer steps from first phase to second phase within a state, and from second phase to the first phase of the next state. After S6 second phase it returns to S1 first phase, so a machine cycle is 12 clocks.
- R2: While `rst_n` is low the outputs are S1 first phase (`state_oh`=000001, `phase2`=0), with `ale`=0, `psen_n`=1, `xrd_n`=1, `xwr_n`=1 and `data_cycle`=0. The first machine cycle after release is an ordinary one.
- R3: In an ordinary cycle `opcode_latch` is high only in S1 first phase, and `operand_fetch` is high only in S4 first phase, in every cycle.
- R4: In an ordinary cycle `pc_inc` is high only in S3 second phase and S6 second phase.
- R5: In an ordinary cycle `ale` is high in S1 second phase, S2 first phase, S4 second phase and S5 first phase, and low elsewhere, whatever the value of `ext_code`.
- R6: With `ext_code`=1, `psen_n` is low in both phases of S3 and S6 of an ordinary cycle. With `ext_code`=0, `psen_n` stays high.
- R7: `xdata_op` and `xdata_write` are sampled only on the clock that ends S6 second phase of an ordinary cycle. If `xdata_op` is 1 there, the next machine cycle is a data cycle, with `data_cycle`=1 for all of its 12 clocks. At the end of a data cycle `xdata_op` is ignored and the next cycle is ordinary.
- R8: In a data cycle `ale`, `opcode_latch`, `operand_fetch` and `pc_inc` stay low and `psen_n` stays high.
- R9: In a data cycle a bus window spans S1 second phase through S3 second phase, which is 5 clocks. In that window `xrd_n` is low if the sampled `xdata_write` was 0, and `xwr_n` is low if it was 1. Both are high at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ext_code | input | 1 | 1 when program memory is external |
| xdata_op | input | 1 | Core requests a data cycle after the current cycle |
| xdata_write | input | 1 | Direction of the requested data cycle (1 = write) |
| state_oh | output | 6 | One-hot current state S1..S6 |
| phase2 | output | 1 | High in the second phase of a state |
| opcode_latch | output | 1 | Pulse: latch opcode into instruction register |
| operand_fetch | output | 1 | Pulse: take second code byte of the cycle |
| pc_inc | output | 1 | Pulse: advance program counter |
| ale | output | 1 | Address-latch enable |
| psen_n | output | 1 | Active-low code-read strobe |
| xrd_n | output | 1 | Active-low data-read window |
| xwr_n | output | 1 | Active-low data-write window |
| data_cycle | output | 1 | High for the whole of a data cycle |

## Verification
The assertions check some properties on every clock. The state code stays one-hot, the phase alternates, and a state holds across its first phase. A data cycle never carries a fetch, an address-latch pulse or a code strobe. The two data windows never overlap, and only appear in a data cycle. A cycle's kind changes only at a cycle boundary, and two data cycles never follow each other. The bench scenarios are needed to show the exact clock on which each strobe rises and falls. They also show that a request counts only at the end of S6, that the direction is taken from the same clock, and that reset in the middle of a data cycle gives a clean ordinary cycle.

// File: rtl/mcseq_pkg.sv
package mcseq_pkg;
  localparam int unsigned STATES = 6;
  localparam int unsigned ST_W   = $clog2(STATES);
  typedef logic [ST_W-1:0] st_t;
  // State indices; strobe placement depends on these positions.
  localparam st_t S1 = st_t'(0);
  localparam st_t S2 = st_t'(1);
  localparam st_t S3 = st_t'(2);
  localparam st_t S4 = st_t'(3);
  localparam st_t S5 = st_t'(4);
  localparam st_t S6 = st_t'(5);
endpackage

// File: rtl/mcseq_timebase.sv
module mcseq_timebase
  import mcseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output st_t  st,
  output logic p2,
  output logic cyc_last
);
  st_t  st_q, st_d;
  logic p2_q, p2_d;
  logic adv_en;

  assign adv_en = 1'b1;

  always_comb begin
    p2_d = ~p2_q;
    st_d = st_q;
    if (p2_q) begin
      st_d = (st_q == S6) ? S1 : st_q + st_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S1;
      p2_q <= 1'b0;
    end else if (adv_en) begin
      st_q <= st_d;
      p2_q <= p2_d;
    end
  end

  assign st       = st_q;
  assign p2       = p2_q;
  assign cyc_last = p2_q & (st_q == S6);
endmodule

// File: rtl/mcseq_cyckind.sv
module mcseq_cyckind (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_last,
  input  logic xdata_op,
  input  logic xdata_write,
  output logic dcyc,
  output logic dwr
);
  logic dcyc_q, dcyc_d;
  logic dwr_q, dwr_d;
  logic ld_en;

  assign ld_en = cyc_last;

  always_comb begin
    // A data cycle is always followed by an ordinary one.
    dcyc_d = ~dcyc_q & xdata_op;
    dwr_d  = xdata_write;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcyc_q <= 1'b0;
      dwr_q  <= 1'b0;
    end else if (ld_en) begin
      dcyc_q <= dcyc_d;
      dwr_q  <= dwr_d;
    end
  end

  assign dcyc = dcyc_q;
  assign dwr  = dwr_q;
endmodule

// File: rtl/mcseq_strobes.sv
module mcseq_strobes
  import mcseq_pkg::*;
(
  input  st_t               st,
  input  logic              p2,
  input  logic              dcyc,
  input  logic              dwr,
  input  logic              ext_code,
  output logic [STATES-1:0] state_oh,
  output logic              opcode_latch,
  output logic              operand_fetch,
  output logic              pc_inc,
  output logic              ale,
  output logic              psen_n,
  output logic              xrd_n,
  output logic              xwr_n
);
  logic fetch_ok;
  logic win;

  for (genvar gi = 0; gi < STATES; gi++) begin : g_oh
    assign state_oh[gi] = (st == st_t'(gi));
  end

  always_comb begin
    fetch_ok      = ~dcyc;
    opcode_latch  = fetch_ok & ~p2 & (st == S1);
    operand_fetch = fetch_ok & ~p2 & (st == S4);
    pc_inc        = fetch_ok &  p2 & ((st == S3) | (st == S6));
    ale           = fetch_ok & (((st == S1) &  p2) | ((st == S2) & ~p2) |
                                ((st == S4) &  p2) | ((st == S5) & ~p2));
    psen_n        = ~(fetch_ok & ext_code & ((st == S3) | (st == S6)));
    win           = dcyc & (((st == S1) & p2) | (st == S2) | (st == S3));
    xrd_n         = ~(win & ~dwr);
    xwr_n         = ~(win &  dwr);
  end
endmodule

// File: rtl/mcycle_sequencer.sv
module mcycle_sequencer
  import mcseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_code,
  input  logic              xdata_op,
  input  logic              xdata_write,
  output logic [STATES-1:0] state_oh,
  output logic              phase2,
  output logic              opcode_latch,
  output logic              operand_fetch,
  output logic              pc_inc,
  output logic              ale,
  output logic              psen_n,
  output logic              xrd_n,
  output logic              xwr_n,
  output logic              data_cycle
);
  st_t  st;
  logic p2;
  logic cyc_last;
  logic dcyc;
  logic dwr;

  mcseq_timebase i_timebase (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st),
    .p2       (p2),
    .cyc_last (cyc_last)
  );

  mcseq_cyckind i_cyckind (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_last    (cyc_last),
    .xdata_op    (xdata_op),
    .xdata_write (xdata_write),
    .dcyc        (dcyc),
    .dwr         (dwr)
  );

  mcseq_strobes i_strobes (
    .st            (st),
    .p2            (p2),
    .dcyc          (dcyc),
    .dwr           (dwr),
    .ext_code      (ext_code),
    .state_oh      (state_oh),
    .opcode_latch  (opcode_latch),
    .operand_fetch (operand_fetch),
    .pc_inc        (pc_inc),
    .ale           (ale),
    .psen_n        (psen_n),
    .xrd_n         (xrd_n),
    .xwr_n         (xwr_n)
  );

  assign phase2     = p2;
  assign data_cycle = dcyc;
endmodule

// File: rtl/mcycle_sequencer_chk.sv
module mcycle_sequencer_chk
  import mcseq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ext_code,
  input logic [STATES-1:0] state_oh,
  input logic              phase2,
  input logic              opcode_latch,
  input logic              operand_fetch,
  input logic              pc_inc,
  input logic              ale,
  input logic              psen_n,
  input logic              xrd_n,
  input logic              xwr_n,
  input logic              data_cycle
);
  logic at_end;
  assign at_end = state_oh[STATES-1] & phase2;

  a_r1_state_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_oh) == 1);
  a_r1_p2_to_p1: assert property (@(posedge clk) disable iff (!rst_n)
    phase2 |=> !phase2);
  a_r1_p1_to_p2: assert property (@(posedge clk) disable iff (!rst_n)
    !phase2 |=> (phase2 && $stable(state_oh)));
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({opcode_latch, operand_fetch, pc_inc}));
  a_r6_internal_no_psen: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_code |-> psen_n);
  a_r7_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (data_cycle && at_end) |=> !data_cycle);
  a_r7_kind_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !at_end |=> $stable(data_cycle));
  a_r8_data_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    data_cycle |-> (psen_n && !ale && !opcode_latch && !operand_fetch && !pc_inc));
  a_r9_rw_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    xrd_n || xwr_n);
  a_r9_window_in_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!xrd_n || !xwr_n) |-> data_cycle);
endmodule

bind mcycle_sequencer mcycle_sequencer_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ext_code      (ext_code),
  .state_oh      (state_oh),
  .phase2        (phase2),
  .opcode_latch  (opcode_latch),
  .operand_fetch (operand_fetch),
  .pc_inc        (pc_inc),
  .ale           (ale),
  .psen_n        (psen_n),
  .xrd_n         (xrd_n),
  .xwr_n         (xwr_n),
  .data_cycle    (data_cycle)
);

// File: tb/test_mcycle_sequencer.sv
`timescale 1ns/1ps
module test_mcycle_sequencer;
  logic       clk;
  logic       rst_n;
  logic       ext_code;
  logic       xdata_op;
  logic       xdata_write;
  logic [5:0] state_oh;
  logic       phase2, opcode_latch, operand_fetch, pc_inc;
  logic       ale, psen_n, xrd_n, xwr_n, data_cycle;

  int n_checks = 0;
  int n_err    = 0;
  int k        = 0;
  bit m_dc     = 0;
  bit m_dw     = 0;

  mcycle_sequencer i_mcycle_sequencer (
    .clk(clk), .rst_n(rst_n), .ext_code(ext_code), .xdata_op(xdata_op),
    .xdata_write(xdata_write), .state_oh(state_oh), .phase2(phase2),
    .opcode_latch(opcode_latch), .operand_fetch(operand_fetch), .pc_inc(pc_inc),
    .ale(ale), .psen_n(psen_n), .xrd_n(xrd_n), .xwr_n(xwr_n), .data_cycle(data_cycle)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog (R1..): actual timeout expected completion");
    summary();
    $finish;
  end

  // Called at a falling edge; drives inputs, checks outputs, advances model.
  task automatic step(input bit ext, input bit xop, input bit xw);
    int  s, p;
    bit  n, win;
    ext_code = ext; xdata_op = xop; xdata_write = xw;
    #1;
    s = (k / 2) % 6;
    p = k % 2;
    n = !m_dc;
    win = m_dc && ((s == 0 && p == 1) || s == 1 || s == 2);
    chk("R1 state/phase", {1'b0, phase2, state_oh}, {1'b0, p[0], 6'(1 << s)});
    chk(n ? "R3 fetch pulses" : "R8 fetch pulses", {6'd0, opcode_latch, operand_fetch},
        {6'd0, n && s == 0 && p == 0, n && s == 3 && p == 0});
    chk(n ? "R4 pc_inc" : "R8 pc_inc", {7'd0, pc_inc},
        {7'd0, n && p == 1 && (s == 2 || s == 5)});
    chk(n ? "R5 ale" : "R8 ale", {7'd0, ale},
        {7'd0, n && ((s == 0 && p == 1) || (s == 1 && p == 0) ||
                     (s == 3 && p == 1) || (s == 4 && p == 0))});
    chk(n ? "R6 psen_n" : "R8 psen_n", {7'd0, psen_n},
        {7'd0, !(n && ext && (s == 2 || s == 5))});
    chk("R9 rd/wr window", {6'd0, xrd_n, xwr_n}, {6'd0, !(win && !m_dw), !(win && m_dw)});
    chk("R7 data_cycle", {7'd0, data_cycle}, {7'd0, m_dc});
    if (k % 12 == 11) begin
      if (!m_dc && xop) begin m_dc = 1; m_dw = xw; end
      else m_dc = 0;
    end
    k++;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    chk("R2 reset state", {1'b0, phase2, state_oh}, 8'h01);
    chk("R2 reset strobes", {3'd0, ale, psen_n, xrd_n, xwr_n, data_cycle}, 8'b0000_1110);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    k = 0; m_dc = 0; m_dw = 0;
  endtask

  initial begin
    rst_n = 1'b0; ext_code = 1'b0; xdata_op = 1'b0; xdata_write = 1'b0;
    @(negedge clk);
    do_reset();
    for (int ext = 0; ext < 2; ext++) begin
      for (int pat = 0; pat < 5; pat++) begin
        for (int c = 0; c < 96; c++) begin
          int  m = k / 12;
          bit  last = (k % 12 == 11);
          bit  xop, xw;
          case (pat)
            0: begin xop = 0; xw = 0; end
            1: begin xop = 1; xw = m[0]; end                       // R7 ignored in data cycle
            2: begin xop = (m % 3 == 1); xw = ((m / 3) % 2 == 1); end
            3: begin xop = !last; xw = 1; end                      // R7 only S6P2 counts
            default: begin xop = last; xw = !m[1]; end
          endcase
          step(ext[0], xop, xw);
        end
      end
    end
    // R2: reset in the middle of a data cycle, then request held high.
    while (!(m_dc && (k % 12 == 4))) step(1'b1, 1'b1, 1'b1);
    do_reset();
    for (int c = 0; c < 48; c++) step(1'b1, 1'b1, 1'b0);
    summary();
    $finish;
  end
endmodule